// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

The sequencer takes one DMA transfer at a time: a byte address, a byte length and a direction. It cuts the transfer into pieces that never cross a cache-line boundary and hands the pieces to a memory-side request port one after another. A piece is not issued until the previous one has been answered. A read is answered with a full line of data. A write is answered with an acknowledgement. When the last byte has been answered, a one-cycle completion pulse reports the identifier that was given to the transfer when it was accepted.

Only the first piece can start inside a line. It begins at the start address's offset within the line and stops at the end of that line or at the end of the transfer, whichever comes first. Every later piece starts on a line boundary and covers a full line or whatever is left. Store data comes from a byte buffer that belongs to the transfer. The sequencer asks the buffer for the bytes at the index of the first byte not yet completed, and it moves them into the lanes of the line that the piece touches. Read data goes the other way: the touched lanes of the returned line are moved down to lane 0 and written back to the same buffer at that index.

Top module: `dma_line_seq`

## Requirements
- R1: `xfer_ready_o` is high exactly when no transfer is in flight. A transfer is accepted on a clock edge where `xfer_valid_i` and `xfer_ready_o` are both high. `xfer_id_o` shows the identifier the next accepted transfer receives. Identifiers start at 0 after reset and advance by one, modulo 2^ID_W, on every accept.
- R2: The first piece of a transfer has byte address equal to the start address. Its line address is that address with the low log2(LINE_BYTES) bits cleared. Its length is min(length, LINE_BYTES − offset), where offset is the start address modulo LINE_BYTES.
- R3: Each later piece has address start + completed bytes, and that address is line-aligned. Its length is min(length − completed, LINE_BYTES).
- R4: `req_valid_o` holds its value, and the request fields stay unchanged, until `req_ready_i` is seen. After a handshake no further request is raised until the matching response arrives.
- R5: For a write piece, `req_store_o` is 1. `req_be_o` has bit b set exactly for lanes offset ≤ b < offset + length. Lane b of `req_wdata_o` (bits 8b+7:8b) carries buffer byte completed + (b − offset), where lane k of `buf_rd_data_i` is buffer byte `buf_rd_idx_o` + k and `buf_rd_idx_o` equals the completed count. For a read piece, `req_store_o` is 0.
- R6: When a data response for a read piece arrives, `buf_wr_en_o` is high in that cycle. `buf_wr_idx_o` is the completed count, `buf_wr_len_o` is the piece length, and lane k of `buf_wr_data_o` is lane offset + k of `rsp_data_i`. As a result the buffer ends up holding memory bytes start … start + length − 1 at indices 0 … length − 1.
- R7: `done_o` pulses high for one cycle, in the cycle after the response that completes the transfer. `done_id_o` then shows the transfer's identifier, and `xfer_ready_o` is high in that same cycle.
- R8: A data response during a write transfer raises `err_o` for one cycle in the next cycle and does not advance the transfer. An acknowledgement during a read transfer is ignored.
- R9: A zero-length transfer is accepted and pulses `done_o` in the next cycle with its identifier. It issues no request and never drops `xfer_ready_o`.
- R10: After reset, `xfer_ready_o` is 1, `req_valid_o`, `done_o` and `err_o` are 0, and `xfer_id_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_valid_i | input | 1 | Transfer offered |
| xfer_ready_o | output | 1 | Sequencer idle, transfer can be taken |
| xfer_addr_i | input | ADDR_W | Start byte address |
| xfer_len_i | input | LEN_W | Transfer length in bytes |
| xfer_write_i | input | 1 | 1 = write, 0 = read |
| xfer_id_o | output | ID_W | Identifier given to the next accepted transfer |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory side takes the request |
| req_addr_o | output | ADDR_W | Full byte address of the piece |
| req_line_o | output | ADDR_W | Line-aligned address of the piece |
| req_store_o | output | 1 | 1 = store, 0 = load |
| req_len_o | output | log2(LINE_BYTES)+1 | Bytes in the piece |
| req_be_o | output | LINE_BYTES | Lanes written by a store |
| req_wdata_o | output | 8·LINE_BYTES | Store data placed at the line lanes |
| rsp_data_valid_i | input | 1 | Line data response |
| rsp_data_i | input | 8·LINE_BYTES | Returned line |
| rsp_ack_i | input | 1 | Store acknowledgement |
| buf_rd_idx_o | output | LEN_W | Buffer index of the store bytes wanted |
| buf_rd_data_i | input | 8·LINE_BYTES | Buffer bytes from that index, lane 0 first |
| buf_wr_en_o | output | 1 | Write gathered read bytes to the buffer |
| buf_wr_idx_o | output | LEN_W | Buffer index of the write |
| buf_wr_len_o | output | log2(LINE_BYTES)+1 | Bytes to write |
| buf_wr_data_o | output | 8·LINE_BYTES | Bytes to write, lane 0 first |
| done_o | output | 1 | Transfer complete pulse |
| done_id_o | output | ID_W | Identifier of the completed transfer |
| err_o | output | 1 | Data response seen during a write |

## Verification
The bench aims at line-crossing cases. These are unaligned starts that run past a line end, starts that end exactly on the last lane, transfers that begin on the final byte of a line, and multi-line reads that end mid-line. An error in the first-piece clip would show up as a piece that crosses a line or is one byte short. An error in the later-piece rule would show up as a misaligned address or a wrong tail length. The bench also checks that a zero-length transfer completes without touching memory, and that a stray response of the wrong kind neither advances the transfer nor is missed as an error. A sequencer that confused offsets would put store bytes in the wrong lanes or gather read bytes to the wrong buffer index. The bench catches this by checking each lane and each gathered byte against memory. Ready stalls check that requests stay stable, and the identifier wraps during the run.

// File: rtl/dma_line_seq_pkg.sv
package dma_line_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0]             start_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [LEN_W-1:0]              done_i,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [ADDR_W-1:0]             line_o,
  output logic [$clog2(LINE_BYTES)-1:0] off_o,
  output logic [$clog2(LINE_BYTES):0]   cnt_o,
  output logic [LINE_BYTES-1:0]         be_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W = OFF_W + 1;

  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] room;
  logic [CNT_W-1:0] end_lane;

  assign addr_o   = start_i + ADDR_W'(done_i);
  assign off_o    = addr_o[OFF_W-1:0];
  assign line_o   = {addr_o[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rem      = len_i - done_i;
  assign room     = LEN_W'(LINE_BYTES) - LEN_W'(off_o);
  // clip to line end or to what remains, whichever is nearer
  assign cnt_o    = (rem < room) ? CNT_W'(rem) : CNT_W'(room);
  assign end_lane = {1'b0, off_o} + cnt_o;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_be
    assign be_o[b] = (CNT_W'(b) >= {1'b0, off_o}) && (CNT_W'(b) < end_lane);
  end
endmodule

// File: rtl/dma_lane_shift.sv
module dma_lane_shift #(
  parameter int LANES = 64,
  parameter int SH_W  = 6,
  parameter bit LEFT  = 1'b1
) (
  input  logic [LANES*8-1:0] data_i,
  input  logic [SH_W-1:0]    sh_i,
  output logic [LANES*8-1:0] data_o
);
  if (LEFT) begin : g_left
    assign data_o = data_i << {sh_i, 3'b000};
  end else begin : g_right
    assign data_o = data_i >> {sh_i, 3'b000};
  end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_line_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          xfer_valid_i,
  output logic                          xfer_ready_o,
  input  logic [ADDR_W-1:0]             xfer_addr_i,
  input  logic [LEN_W-1:0]              xfer_len_i,
  input  logic                          xfer_write_i,
  output logic [ID_W-1:0]               xfer_id_o,
  output logic                          req_valid_o,
  input  logic                          req_ready_i,
  output logic [ADDR_W-1:0]             req_addr_o,
  output logic [ADDR_W-1:0]             req_line_o,
  output logic                          req_store_o,
  output logic [$clog2(LINE_BYTES):0]   req_len_o,
  output logic [LINE_BYTES-1:0]         req_be_o,
  output logic [LINE_BYTES*8-1:0]       req_wdata_o,
  input  logic                          rsp_data_valid_i,
  input  logic [LINE_BYTES*8-1:0]       rsp_data_i,
  input  logic                          rsp_ack_i,
  output logic [LEN_W-1:0]              buf_rd_idx_o,
  input  logic [LINE_BYTES*8-1:0]       buf_rd_data_i,
  output logic                          buf_wr_en_o,
  output logic [LEN_W-1:0]              buf_wr_idx_o,
  output logic [$clog2(LINE_BYTES):0]   buf_wr_len_o,
  output logic [LINE_BYTES*8-1:0]       buf_wr_data_o,
  output logic                          done_o,
  output logic [ID_W-1:0]               done_id_o,
  output logic                          err_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CNT_W  = OFF_W + 1;
  localparam int DATA_W = LINE_BYTES * 8;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W-1:0]   next_id_q;
  logic [LEN_W-1:0]  issued_q;
  logic [LEN_W-1:0]  cmpl_q;
  logic              done_q;
  logic              err_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] cur_line;
  logic [OFF_W-1:0]  cur_off;
  logic [CNT_W-1:0]  cur_cnt;
  logic [LINE_BYTES-1:0] cur_be;
  logic [DATA_W-1:0] wdata_sh;
  logic [DATA_W-1:0] rdata_sh;

  logic busy, accept, req_hs, rsp_ok, bad_data;

  dma_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .start_i(start_q), .len_i(len_q), .done_i(cmpl_q),
    .addr_o(cur_addr), .line_o(cur_line), .off_o(cur_off),
    .cnt_o(cur_cnt), .be_o(cur_be)
  );

  dma_lane_shift #(.LANES(LINE_BYTES), .SH_W(OFF_W), .LEFT(1'b1)) u_wr_place (
    .data_i(buf_rd_data_i), .sh_i(cur_off), .data_o(wdata_sh)
  );

  dma_lane_shift #(.LANES(LINE_BYTES), .SH_W(OFF_W), .LEFT(1'b0)) u_rd_align (
    .data_i(rsp_data_i), .sh_i(cur_off), .data_o(rdata_sh)
  );

  assign busy     = (state_q != ST_IDLE);
  assign accept   = xfer_valid_i && !busy;
  assign req_hs   = req_valid_o && req_ready_i;
  assign rsp_ok   = (state_q == ST_WAIT) && (wr_q ? rsp_ack_i : rsp_data_valid_i);
  assign bad_data = busy && wr_q && rsp_data_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      start_q   <= '0;
      len_q     <= '0;
      wr_q      <= 1'b0;
      id_q      <= '0;
      next_id_q <= '0;
      issued_q  <= '0;
      cmpl_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= bad_data;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            start_q   <= xfer_addr_i;
            len_q     <= xfer_len_i;
            wr_q      <= xfer_write_i;
            id_q      <= next_id_q;
            next_id_q <= next_id_q + 1'b1;
            issued_q  <= '0;
            cmpl_q    <= '0;
            if (xfer_len_i == '0) done_q  <= 1'b1;
            else                  state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_hs) begin
            issued_q <= issued_q + LEN_W'(cur_cnt);
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_ok) begin
            cmpl_q <= issued_q;
            if (issued_q == len_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_ready_o  = !busy;
  assign xfer_id_o     = next_id_q;
  assign req_valid_o   = (state_q == ST_ISSUE);
  assign req_addr_o    = cur_addr;
  assign req_line_o    = cur_line;
  assign req_store_o   = wr_q;
  assign req_len_o     = cur_cnt;
  assign req_be_o      = wr_q ? cur_be : '0;
  assign req_wdata_o   = wdata_sh;
  assign buf_rd_idx_o  = cmpl_q;
  assign buf_wr_en_o   = (state_q == ST_WAIT) && !wr_q && rsp_data_valid_i;
  assign buf_wr_idx_o  = cmpl_q;
  assign buf_wr_len_o  = cur_cnt;
  assign buf_wr_data_o = rdata_sh;
  assign done_o        = done_q;
  assign done_id_o     = id_q;
  assign err_o         = err_q;

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && xfer_valid_i |=> $stable(start_q) && $stable(len_q)); // R1

  AST_PIECE_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) &&
      (({1'b0, req_addr_o[OFF_W-1:0]} + req_len_o) <= CNT_W'(LINE_BYTES))); // R2

  AST_LATER_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && (cmpl_q != '0) |-> (req_addr_o[OFF_W-1:0] == '0)); // R3

  AST_ISSUED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (issued_q <= len_q) && (cmpl_q <= issued_q)); // R3

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
      $stable(req_len_o)); // R4

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> xfer_ready_o && !req_valid_o); // R7
endmodule

// File: tb/dma_line_seq_bench.sv
module dma_line_seq_bench;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int LB = 16;
  localparam int IW = 3;
  localparam int DW = LB * 8;
  localparam int CW = $clog2(LB) + 1;
  localparam int NXFER = 11;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          xfer_valid = 1'b0, xfer_write = 1'b0;
  logic [AW-1:0] xfer_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic          xfer_ready;
  logic [IW-1:0] xfer_id;
  logic          req_valid, req_store;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr, req_line;
  logic [CW-1:0] req_len;
  logic [LB-1:0] req_be;
  logic [DW-1:0] req_wdata;
  logic          rsp_dv = 1'b0, rsp_ack = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [LW-1:0] buf_rd_idx, buf_wr_idx;
  logic [DW-1:0] buf_rd_data, buf_wr_data;
  logic          buf_wr_en;
  logic [CW-1:0] buf_wr_len;
  logic          done_o, err_o;
  logic [IW-1:0] done_id;

  dma_line_seq #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .ID_W(IW)) u_dma_line_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .xfer_valid_i(xfer_valid), .xfer_ready_o(xfer_ready), .xfer_addr_i(xfer_addr),
    .xfer_len_i(xfer_len), .xfer_write_i(xfer_write), .xfer_id_o(xfer_id),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_line_o(req_line), .req_store_o(req_store), .req_len_o(req_len),
    .req_be_o(req_be), .req_wdata_o(req_wdata),
    .rsp_data_valid_i(rsp_dv), .rsp_data_i(rsp_data), .rsp_ack_i(rsp_ack),
    .buf_rd_idx_o(buf_rd_idx), .buf_rd_data_i(buf_rd_data), .buf_wr_en_o(buf_wr_en),
    .buf_wr_idx_o(buf_wr_idx), .buf_wr_len_o(buf_wr_len), .buf_wr_data_o(buf_wr_data),
    .done_o(done_o), .done_id_o(done_id), .err_o(err_o)
  );

  logic [7:0] wbuf [0:255];
  logic [7:0] rbuf [0:255];

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(a * 7 + 3);
  endfunction

  always_comb begin
    for (int k = 0; k < LB; k++)
      buf_rd_data[k*8 +: 8] = (int'(buf_rd_idx) + k < 256) ? wbuf[int'(buf_rd_idx) + k] : 8'h00;
  end

  always @(posedge clk) begin
    if (buf_wr_en)
      for (int k = 0; k < int'(buf_wr_len); k++)
        if (int'(buf_wr_idx) + k < 256) rbuf[int'(buf_wr_idx) + k] <= buf_wr_data[k*8 +: 8];
  end

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  int p_addr[$], p_len[$];
  bit p_wr[$], p_inj[$];

  int m_start, m_len, m_issued, m_done, m_line, m_phase, m_id;
  int exp_id, rsp_delay, d_id, d_start, d_len, ndone;
  bit m_wr, m_busy, m_inj, exp_done, exp_err, d_rd, running;

  initial begin
    m_phase = 0; m_busy = 0; exp_id = 0; ndone = 0; exp_done = 0; exp_err = 0;
    rsp_delay = 0; running = 0; m_inj = 0;
  end

  always @(negedge clk) begin
    int ph0, cur, off, room, rem, chunk;
    longint bem;
    if (running) begin
      ph0 = m_phase;
      chk(done_o == exp_done, "R7 done pulse timing", done_o, exp_done);
      if (done_o && exp_done) begin
        chk(done_id == IW'(d_id), "R7 done id", done_id, d_id);
        ndone++;
        if (d_rd)
          for (int i = 0; i < d_len; i++)
            chk(rbuf[i] == mem_byte(d_start + i), "R6 gathered read byte", rbuf[i], mem_byte(d_start + i));
      end
      chk(err_o == exp_err, "R8 error flag", err_o, exp_err);
      exp_done = 0;
      exp_err = 0;
      chk(xfer_ready == !m_busy, "R1 ready while idle only", xfer_ready, !m_busy);
      chk(req_valid == (ph0 == 1), "R4 request valid window (R9 none for zero length)", req_valid, ph0 == 1);

      xfer_valid = 0;
      rsp_dv = 0;
      rsp_ack = 0;

      if (ph0 == 2) begin
        if (rsp_delay > 0) rsp_delay--;
        else if (m_inj) begin
          m_inj = 0;
          rsp_delay = 1;
          if (m_wr) begin rsp_dv = 1; rsp_data = '1; exp_err = 1; end
          else rsp_ack = 1;
        end else begin
          if (!m_wr) begin
            rsp_dv = 1;
            for (int k = 0; k < LB; k++) rsp_data[k*8 +: 8] = mem_byte(m_line + k);
          end else rsp_ack = 1;
          m_done = m_issued;
          if (m_done == m_len) begin
            m_phase = 0; m_busy = 0; exp_done = 1;
            d_id = m_id; d_rd = !m_wr; d_start = m_start; d_len = m_len;
          end else m_phase = 1;
        end
      end

      req_ready = ((cyc % 7) >= 2);

      if (ph0 == 1 && req_valid) begin
        cur = m_start + m_done;
        off = cur % LB;
        room = LB - off;
        rem = m_len - m_done;
        chunk = (rem < room) ? rem : room;
        bem = ((64'd1 << chunk) - 1) << off;
        if (m_done == 0) begin
          chk(req_addr == AW'(cur), "R2 first address", req_addr, cur);
          chk(req_len == CW'(chunk), "R2 first length", req_len, chunk);
        end else begin
          chk(req_addr == AW'(cur) && off == 0, "R3 later aligned address", req_addr, cur);
          chk(req_len == CW'(chunk), "R3 later length", req_len, chunk);
        end
        chk(req_line == AW'(cur - off), "R2 line address", req_line, cur - off);
        chk(req_store == m_wr, "R5 store type", req_store, m_wr);
        if (m_wr) begin
          chk(req_be == LB'(bem), "R5 byte enables", req_be, bem);
          for (int b = off; b < off + chunk; b++)
            chk(req_wdata[b*8 +: 8] == wbuf[m_done + b - off], "R5 store lane byte",
                req_wdata[b*8 +: 8], wbuf[m_done + b - off]);
        end
        if (req_ready) begin
          m_issued = m_issued + chunk;
          m_line = cur - off;
          m_phase = 2;
          rsp_delay = cyc % 3;
        end
      end

      if (!m_busy && xfer_ready && p_addr.size() > 0 && (cyc % 4) != 1) begin
        chk(xfer_id == IW'(exp_id), "R1 next id", xfer_id, exp_id);
        xfer_valid = 1;
        xfer_addr = AW'(p_addr[0]);
        xfer_len = LW'(p_len[0]);
        xfer_write = p_wr[0];
        m_start = p_addr.pop_front();
        m_len = p_len.pop_front();
        m_wr = p_wr.pop_front();
        m_inj = p_inj.pop_front();
        m_id = exp_id;
        exp_id = (exp_id + 1) % (1 << IW);
        m_issued = 0;
        m_done = 0;
        if (m_len == 0) begin
          exp_done = 1; d_id = m_id; d_rd = 0;
        end else begin
          m_busy = 1; m_phase = 1;
        end
      end
    end
  end

  task automatic add(input int a, input int l, input bit w, input bit inj);
    p_addr.push_back(a); p_len.push_back(l); p_wr.push_back(w); p_inj.push_back(inj);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) wbuf[i] = 8'(i * 29 + 1);
    add('h100, 16, 0, 0);
    add('h105, 4, 0, 0);
    add('h10C, 40, 1, 0);
    add('h203, 13, 0, 0);
    add('h300, 0, 0, 0);   // R9
    add('h3F1, 47, 0, 1);  // R8 stray ack on read
    add('h40A, 6, 1, 1);   // R8 data on write
    add('h500, 32, 1, 0);
    add('h7FF, 2, 1, 0);
    add('h600, 0, 1, 0);   // R9
    add('h123, 100, 0, 0);
    repeat (3) @(negedge clk);
    chk(xfer_ready == 1'b1, "R10 reset ready", xfer_ready, 1);
    chk(req_valid == 1'b0, "R10 reset request", req_valid, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R10 reset pulses", {done_o, err_o}, 0);
    chk(xfer_id == '0, "R10 reset id", xfer_id, 0);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    while (!(p_addr.size() == 0 && !m_busy && ndone == NXFER) && cyc < LIMIT) @(negedge clk);
    repeat (3) @(negedge clk);
    if (cyc >= LIMIT) chk(1'b0, "watchdog expired", cyc, LIMIT);
    chk(ndone == NXFER, "R7 completion count", ndone, NXFER);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule